// File: doc/BRIEF.md
# GPIO Port Bank with Change Interrupt

This block is the register core of a small general-purpose I/O port. A bus interface hands it single-cycle register reads and writes. The block holds four registers. The drive register sets the value each output pin puts out. The direction register makes each pin an input or an output. The invert register flips the bits returned when the pins are read. The pin register is read-only and shows the synchronised level of every pad. Pads are modelled with separate output-enable and output-data vectors and a raw input vector.

Every pad input passes through a two-stage synchroniser before anything uses it. The block keeps a snapshot of the pin levels. It pulls an active-low, open-drain style interrupt line whenever an input-configured pin differs from that snapshot. Reading the pin register retakes the snapshot, which clears the interrupt.

Top module: `gpio_bank_top`

## Requirements
- R1: While `rstN` is low and after it rises, the drive register reads 8'hFF, the invert register reads 8'h00, the direction register reads 8'hFF (all inputs), `padOe` is all zero and the pin snapshot is zero.
- R2: A pin whose direction bit is 0 is an output: its `padOe` bit is 1 and its `padOut` bit equals the drive register bit. A direction bit of 1 gives `padOe` 0.
- R3: Writes with `regAddr` 1 (drive), 2 (invert) or 3 (direction) load `regWrData` at the clock edge. Read data reflects the addressed register combinationally, whatever the state of `regRdEn`.
- R4: Reading `regAddr` 0 returns the synchronised level of every pad, whether that pin is an input or an output.
- R5: Each invert bit set to 1 flips the matching bit of the `regAddr` 0 read data. A bit of 0 leaves it unchanged.
- R6: A write to `regAddr` 0 changes no register and no output.
- R7: A pad change becomes visible in the read data two clock edges after it is applied, and not after one.
- R8: `intN` goes low when any input-configured pin's synchronised level differs from the snapshot.
- R9: A read of `regAddr` 0 with `regRdEn` high and `regWrEn` low copies the synchronised pins into the snapshot at that edge, so `intN` returns high if the pins are stable.
- R10: If a changed input pin returns to its snapshot value before any read, `intN` returns high.
- R11: Pins configured as outputs never pull `intN` low.
- R12: Taking `rstN` low in the middle of operation restores every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 pins, 1 drive, 2 invert, 3 direction |
| regWrEn | input | 1 | Write strobe, one cycle per access |
| regRdEn | input | 1 | Read strobe; a pin-register read retakes the snapshot |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register |
| padIn | input | 8 | Raw pad input levels |
| padOe | output | 8 | Pad output enable, 1 = drive |
| padOut | output | 8 | Pad output data |
| intN | output | 1 | Change interrupt, active low |

## Verification
The bench loops output pads back onto `padIn` to show that output pins still read their driven level. A design that sampled only input pins would return external values there instead. It samples the read data one edge and two edges after a pad change, so a synchroniser that is too short or too long gets caught. Toggling an input pin away and back before any read shows whether the interrupt tracks the live mismatch or latches, and a loopback change on an output pin catches a missing direction mask. Writing the read-only address and then reading every register back exposes a decoder that lets such a write leak into the drive register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    REG_PINS   = 2'd0,
    REG_DRIVE  = 2'd1,
    REG_INVERT = 2'd2,
    REG_DIR    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadDrive;
    logic loadInvert;
    logic loadDir;
    logic snapPins;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   regAddr,
  input  logic         regWrEn,
  input  logic         regRdEn,
  output regSel_e      regSel,
  output ctrlStrobes_t strobes
);
  always_comb begin
    regSel = regSel_e'(regAddr);
    strobes = '0;
    if (regWrEn) begin
      unique case (regSel)
        REG_DRIVE:  strobes.loadDrive  = 1'b1;
        REG_INVERT: strobes.loadInvert = 1'b1;
        REG_DIR:    strobes.loadDir    = 1'b1;
        default:    ;
      endcase
    end else if (regRdEn && regSel == REG_PINS) begin
      strobes.snapPins = 1'b1;
    end
  end

  // A write to the read-only pin register raises no load strobe
  assert_pinreg_write_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0) |-> !(strobes.loadDrive || strobes.loadInvert || strobes.loadDir));

  // At most one register is loaded per access
  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadDrive, strobes.loadInvert, strobes.loadDir, strobes.snapPins}));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  regSel_e          regSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic             intN
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] syncChain [SYNC_STAGES];
  logic [WIDTH-1:0] pinLevel;
  logic [WIDTH-1:0] snapshot;
  logic [WIDTH-1:0] driveReg;
  logic [WIDTH-1:0] invertReg;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] changedPins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign pinLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveReg  <= ALL_ONES;
      invertReg <= '0;
      dirReg    <= ALL_ONES;
      snapshot  <= '0;
    end else begin
      if (strobes.loadDrive)  driveReg  <= wrData;
      if (strobes.loadInvert) invertReg <= wrData;
      if (strobes.loadDir)    dirReg    <= wrData;
      if (strobes.snapPins)   snapshot  <= pinLevel;
    end
  end

  always_comb begin
    unique case (regSel)
      REG_PINS:   rdData = pinLevel ^ invertReg;
      REG_DRIVE:  rdData = driveReg;
      REG_INVERT: rdData = invertReg;
      default:    rdData = dirReg;
    endcase
  end

  assign padOe       = ~dirReg;
  assign padOut      = driveReg;
  assign changedPins = (pinLevel ^ snapshot) & dirReg;
  assign intN        = ~|changedPins;

  // Retaking the snapshot on stable pins clears the interrupt
  assert_snap_clears_int_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snapPins |=> (intN || (pinLevel != $past(pinLevel))));

  // With every pin an output the interrupt stays released
  assert_outputs_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (padOe == ALL_ONES) |-> intN);

  // Direction only changes through its own load strobe
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDir |=> $stable(padOe));

  // A pad level reaches the pin register through the full synchroniser
  assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    $stable(syncChain[0]) |=> (pinLevel == $past(syncChain[0])));
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic             intN
);
  ctrlStrobes_t strobes;
  regSel_e      regSel;

  gpio_bank_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regSel  (regSel),
    .strobes (strobes)
  );

  gpio_bank_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regSel  (regSel),
    .wrData  (regWrData),
    .padIn   (padIn),
    .rdData  (regRdData),
    .padOe   (padOe),
    .padOut  (padOut),
    .intN    (intN)
  );
endmodule

// File: tb/test_gpio_bank_top.sv
`timescale 1ns/1ps
module test_gpio_bank_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [7:0] padIn;
  logic [7:0] padOe;
  logic [7:0] padOut;
  logic       intN;
  logic [7:0] extPins = 8'h00;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign padIn = (padOe & padOut) | (~padOe & extPins);

  gpio_bank_top i_gpio_bank_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .intN(intN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    extPins = 8'h00;
    cycles(2);
    rstN = 1'b1;
    cycles(1);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peekReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic readPins(output logic [7:0] d);
    @(negedge clk);
    regAddr = 2'd0; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    @(negedge clk);
    rstN = 1'b0;
    cycles(1);
    peekReg(2'd1, v); check("R1 drive in reset", v, 8'hFF);
    rstN = 1'b1;
    cycles(1);
    peekReg(2'd1, v); check("R1 drive", v, 8'hFF);
    peekReg(2'd2, v); check("R1 invert", v, 8'h00);
    peekReg(2'd3, v); check("R1 direction", v, 8'hFF);
    check("R1 padOe", padOe, 8'h00);
    check("R1 intN", {7'd0, intN}, 8'h01);
  endtask

  task automatic testOutputs();
    logic [7:0] v;
    applyReset();
    writeReg(2'd1, 8'hA5);
    writeReg(2'd3, 8'hF0);
    peekReg(2'd1, v); check("R3 drive readback", v, 8'hA5);
    peekReg(2'd3, v); check("R3 dir readback", v, 8'hF0);
    check("R2 padOe", padOe, 8'h0F);
    check("R2 padOut", padOut, 8'hA5);
    extPins = 8'h30;
    cycles(3);
    readPins(v); check("R4 pins read with outputs", v, 8'h35);
    writeReg(2'd2, 8'hFF);
    peekReg(2'd2, v); check("R3 invert readback", v, 8'hFF);
    peekReg(2'd0, v); check("R5 all inverted", v, 8'hCA);
    writeReg(2'd2, 8'h11);
    peekReg(2'd0, v); check("R5 partial invert", v, 8'h24);
  endtask

  task automatic testPinWrite();
    logic [7:0] v;
    applyReset();
    extPins = 8'h0C;
    cycles(3);
    writeReg(2'd0, 8'h5A);
    peekReg(2'd0, v); check("R6 pin reg unchanged", v, 8'h0C);
    peekReg(2'd1, v); check("R6 drive unchanged", v, 8'hFF);
    peekReg(2'd2, v); check("R6 invert unchanged", v, 8'h00);
    peekReg(2'd3, v); check("R6 dir unchanged", v, 8'hFF);
    check("R6 padOe unchanged", padOe, 8'h00);
  endtask

  task automatic testLatency();
    logic [7:0] v;
    applyReset();
    @(negedge clk);
    extPins = 8'h81;
    peekReg(2'd0, v); check("R7 before edge", v, 8'h00);
    @(negedge clk);
    peekReg(2'd0, v); check("R7 one edge", v, 8'h00);
    @(negedge clk);
    peekReg(2'd0, v); check("R7 two edges", v, 8'h81);
  endtask

  task automatic testInterrupt();
    logic [7:0] v;
    applyReset();
    check("R8 idle released", {7'd0, intN}, 8'h01);
    @(negedge clk); extPins = 8'h08;
    cycles(2);
    check("R8 change asserts", {7'd0, intN}, 8'h00);
    extPins = 8'h00;
    cycles(2);
    check("R10 return releases", {7'd0, intN}, 8'h01);
    extPins = 8'h40;
    cycles(3);
    check("R8 second change", {7'd0, intN}, 8'h00);
    readPins(v);
    check("R9 read value", v, 8'h40);
    check("R9 read clears", {7'd0, intN}, 8'h01);
    extPins = 8'h00;
    cycles(3);
    check("R8 change vs new snapshot", {7'd0, intN}, 8'h00);
  endtask

  task automatic testMask();
    logic [7:0] v;
    applyReset();
    writeReg(2'd3, 8'hF0);
    cycles(3);
    readPins(v);
    check("R11 snapshot taken", {7'd0, intN}, 8'h01);
    writeReg(2'd1, 8'hF0);
    cycles(3);
    peekReg(2'd0, v); check("R11 loopback moved", v, 8'h00);
    check("R11 output change masked", {7'd0, intN}, 8'h01);
  endtask

  task automatic testMidReset();
    logic [7:0] v;
    applyReset();
    writeReg(2'd1, 8'h12);
    writeReg(2'd2, 8'h34);
    writeReg(2'd3, 8'h56);
    applyReset();
    peekReg(2'd1, v); check("R12 drive", v, 8'hFF);
    peekReg(2'd2, v); check("R12 invert", v, 8'h00);
    peekReg(2'd3, v); check("R12 direction", v, 8'hFF);
    check("R12 padOe", padOe, 8'h00);
  endtask

  initial begin
    testReset();
    testOutputs();
    testPinWrite();
    testLatency();
    testInterrupt();
    testMask();
    testMidReset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule